// File: doc/BRIEF.md
# Bit-Serial Add/Subtract Slice

This block adds or subtracts two serial operands that arrive one bit per clock, least significant bit first. A start-of-word strobe is high for exactly one cycle, on the cycle that carries a word's least significant bit. On that cycle the internal carry (add) or borrow (subtract) is taken as zero. Each word's arithmetic therefore starts clean, even when words follow each other with no idle cycle between them. The result bit is registered, so it appears one cycle after its input bits. The strobe is delayed by the same cycle and driven out next to the result, so slices can be chained.

Two parameters fix the slice at build time. `OP` picks addition or subtraction (A minus B). `ZERO_B_AT_LSB` picks the variant. In the zeroing variant, operand B is also forced to zero on the strobe cycle. This variant belongs inside constant-coefficient multiplier arrays, where every slice sees the same strobe at the same time and the neighbour input still holds the tail of the previous word. The non-zeroing variant always uses both operands and suits the combination of independent results, for example summing the outputs of two multipliers.

Top module: `bs_arith_slice`

## Requirements
- R1: With `OP` set to add and `ZERO_B_AT_LSB` = 0, the output bits of an n-bit word, taken LSB first, form (A + B) mod 2^n, where A and B are the words presented on `a_i` and `b_i`.
- R2: With `OP` set to subtract and `ZERO_B_AT_LSB` = 0, the output word is (A − B) mod 2^n.
- R3: On a cycle where `lsb_i` = 1, the carry or borrow left by the previous word does not enter the result, so a full carry out of one word never changes the next word.
- R4: With `ZERO_B_AT_LSB` = 1, bit 0 of operand B is taken as 0. The output word is then (A ± (B with bit 0 cleared)) mod 2^n, and output bit 0 equals input bit 0 of A.
- R5: With `ZERO_B_AT_LSB` = 0, bit 0 of operand B is used, and output bit 0 equals a0 XOR b0.
- R6: Each output bit on `y_o` appears exactly one clock after its input bits were sampled.
- R7: `lsb_o` is `lsb_i` delayed by one clock, so it is high with the output's least significant bit.
- R8: A synchronous reset drives `y_o`, `lsb_o` and the carry/borrow state to 0.
- R9: A new word may start on the cycle right after the previous word's most significant bit, and both words come out correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 1 | Serial operand A, LSB first |
| b_i | input | 1 | Serial operand B, LSB first (neighbour input when chained) |
| lsb_i | input | 1 | High for one cycle with each word's least significant bit |
| y_o | output | 1 | Registered serial sum or difference |
| lsb_o | output | 1 | `lsb_i` delayed one cycle, aligned with the LSB of `y_o` |

## Verification
The only hidden state is one carry or borrow bit. If that bit is wrong, the error shows on `y_o` one cycle after the bit it corrupts. From there it ripples into the higher bits of the same word. It must never reach the first bit of the next word. A carry that survives the strobe therefore shows as a wrong LSB in the following word, one cycle after that word's strobe. A neighbour input that is not zeroed in the zeroing variant shows as output bit 0 differing from A's bit 0. All four parameter combinations run side by side on the same streams. Random and directed streams are used, and they include saturated words that force a carry or borrow out of the top bit.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } bsa_op_e;

  function automatic logic add_res(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic add_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic sub_res(input logic a, input logic b, input logic br);
    return a ^ b ^ br;
  endfunction

  function automatic logic sub_borrow(input logic a, input logic b, input logic br);
    return (~a & b) | (~(a ^ b) & br);
  endfunction

endpackage

// File: rtl/bsa_gate.sv
module bsa_gate #(
  parameter bit ZERO_B = 1'b0
) (
  input  logic b_i,
  input  logic lsb_i,
  input  logic cy_q,
  output logic b_use,
  output logic cy_use
);
  // carry/borrow from the previous word never enters a new word
  assign cy_use = cy_q & ~lsb_i;

  generate
    if (ZERO_B) begin : g_zero_b
      assign b_use = b_i & ~lsb_i;
    end else begin : g_keep_b
      assign b_use = b_i;
    end
  endgenerate
endmodule

// File: rtl/bsa_cell.sv
module bsa_cell
  import bsa_pkg::*;
#(
  parameter bsa_op_e OP = OP_ADD
) (
  input  logic a,
  input  logic b,
  input  logic cy,
  output logic res,
  output logic cy_next
);
  generate
    if (OP == OP_SUB) begin : g_sub
      assign res     = sub_res(a, b, cy);
      assign cy_next = sub_borrow(a, b, cy);
    end else begin : g_add
      assign res     = add_res(a, b, cy);
      assign cy_next = add_carry(a, b, cy);
    end
  endgenerate
endmodule

// File: rtl/bsa_regs.sv
module bsa_regs (
  input  logic clk,
  input  logic rst,
  input  logic res_d,
  input  logic cy_d,
  input  logic lsb_d,
  output logic res_q,
  output logic cy_q,
  output logic lsb_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= 1'b0;
      cy_q  <= 1'b0;
      lsb_q <= 1'b0;
    end else begin
      res_q <= res_d;
      cy_q  <= cy_d;
      lsb_q <= lsb_d;
    end
  end
endmodule

// File: rtl/bs_arith_slice.sv
module bs_arith_slice
  import bsa_pkg::*;
#(
  parameter bsa_op_e OP            = OP_ADD,
  parameter bit      ZERO_B_AT_LSB = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic a_i,
  input  logic b_i,
  input  logic lsb_i,
  output logic y_o,
  output logic lsb_o
);
  // named internal events for the assertions
  logic b_use;
  logic cy_use;
  logic cy_q;
  logic res_d;
  logic cy_d;

  bsa_gate #(.ZERO_B(ZERO_B_AT_LSB)) u_gate (
    .b_i   (b_i),
    .lsb_i (lsb_i),
    .cy_q  (cy_q),
    .b_use (b_use),
    .cy_use(cy_use)
  );

  bsa_cell #(.OP(OP)) u_cell (
    .a      (a_i),
    .b      (b_use),
    .cy     (cy_use),
    .res    (res_d),
    .cy_next(cy_d)
  );

  bsa_regs u_regs (
    .clk  (clk),
    .rst  (rst),
    .res_d(res_d),
    .cy_d (cy_d),
    .lsb_d(lsb_i),
    .res_q(y_o),
    .cy_q (cy_q),
    .lsb_q(lsb_o)
  );

  // R7: strobe travels with the data
  p_lsb_follow_r7: assert property (@(posedge clk) disable iff (rst)
    lsb_i |=> lsb_o);
  p_lsb_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !lsb_i |=> !lsb_o);

  generate
    if (ZERO_B_AT_LSB) begin : g_chk_zero
      p_clear_lsb_r4: assert property (@(posedge clk) disable iff (rst)
        lsb_i |=> (y_o == $past(a_i)));
    end else begin : g_chk_keep
      p_keep_lsb_r5: assert property (@(posedge clk) disable iff (rst)
        lsb_i |=> (y_o == $past(a_i ^ b_i)));
    end

    if (OP == OP_SUB) begin : g_chk_sub
      p_borrow_gen_r2: assert property (@(posedge clk) disable iff (rst)
        (!a_i && b_use) |=> cy_q);
      p_borrow_kill_r3: assert property (@(posedge clk) disable iff (rst)
        (lsb_i && a_i && !b_use) |=> !cy_q);
    end else begin : g_chk_add
      p_carry_gen_r1: assert property (@(posedge clk) disable iff (rst)
        (a_i && b_use) |=> cy_q);
      p_carry_kill_r3: assert property (@(posedge clk) disable iff (rst)
        (lsb_i && !a_i && !b_use) |=> !cy_q);
    end
  endgenerate
endmodule

// File: tb/bs_arith_slice_bench.sv
`timescale 1ns/1ps
module bs_arith_slice_bench;
  import bsa_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a = 1'b0, b = 1'b0, lsb = 1'b0;
  logic [3:0] y, lo;
  logic [3:0] exp_y;
  logic exp_l;
  logic pend = 1'b0;
  logic done = 1'b0;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  // k: bit0 = subtract, bit1 = zeroing variant
  bs_arith_slice #(.OP(OP_ADD), .ZERO_B_AT_LSB(1'b0)) u_bs_arith_slice (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .lsb_i(lsb), .y_o(y[0]), .lsb_o(lo[0]));
  bs_arith_slice #(.OP(OP_SUB), .ZERO_B_AT_LSB(1'b0)) u_sub_keep (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .lsb_i(lsb), .y_o(y[1]), .lsb_o(lo[1]));
  bs_arith_slice #(.OP(OP_ADD), .ZERO_B_AT_LSB(1'b1)) u_add_zero (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .lsb_i(lsb), .y_o(y[2]), .lsb_o(lo[2]));
  bs_arith_slice #(.OP(OP_SUB), .ZERO_B_AT_LSB(1'b1)) u_sub_zero (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .lsb_i(lsb), .y_o(y[3]), .lsb_o(lo[3]));

  function automatic logic [15:0] ref_word(input int k, input logic [15:0] wa,
                                           input logic [15:0] wb);
    logic [15:0] bx;
    bx = k[1] ? {wb[15:1], 1'b0} : wb;
    return k[0] ? (wa - bx) : (wa + bx);
  endfunction

  task automatic chk(input logic got, input logic want, input string tag);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, want, $time);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      for (int k = 0; k < 4; k++) begin
        string tag;
        tag = k[0] ? "R2" : "R1";
        if (exp_l) tag = {tag, k[1] ? "/R4/R3" : "/R5/R3"};
        tag = {tag, "/R6/R9"};
        chk(y[k], exp_y[k], tag);
        chk(lo[k], exp_l, "R7");
      end
    end
  endtask

  task automatic send_word(input int len, input logic [15:0] wa, input logic [15:0] wb);
    logic [15:0] r [4];
    for (int k = 0; k < 4; k++) r[k] = ref_word(k, wa, wb);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check_pending();
      a = wa[i]; b = wb[i]; lsb = (i == 0);
      for (int k = 0; k < 4; k++) exp_y[k] = r[k][i];
      exp_l = (i == 0);
      pend = 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int k = 0; k < 4; k++) begin
      chk(y[k], 1'b0, "R8 y");
      chk(lo[k], 1'b0, "R8 lsb");
    end
    rst = 1'b0;
    // directed: saturated words then zero words, back to back (R3, R9)
    send_word(16, 16'hFFFF, 16'hFFFF);
    send_word(16, 16'h0000, 16'h0000);
    send_word(8, 16'h0000, 16'h00FF);
    send_word(8, 16'h0000, 16'h0000);
    send_word(4, 16'h0000, 16'h0002);
    send_word(4, 16'h0001, 16'h0001);
    send_word(2, 16'h0003, 16'h0003);
    send_word(1, 16'h0001, 16'h0001);
    send_word(1, 16'h0000, 16'h0001);
    // random words of random length
    for (int w = 0; w < 300; w++) begin
      int len;
      len = 1 + int'($urandom_range(15));
      send_word(len, 16'($urandom), 16'($urandom));
    end
    // R8: reset mid-word
    send_word(16, 16'hFFFF, 16'h0001);
    @(negedge clk);
    check_pending();
    a = 1'b1; b = 1'b1; lsb = 1'b0; pend = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk(y[k], 1'b0, "R8 y mid-word");
      chk(lo[k], 1'b0, "R8 lsb mid-word");
    end
    rst = 1'b0;
    send_word(16, 16'h1234, 16'h0FF1);
    for (int w = 0; w < 50; w++) send_word(16, 16'($urandom), 16'($urandom));
    @(negedge clk);
    check_pending();
    pend = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule